// File: doc/BRIEF.md
# Dual-Address I2C Target Controller

This block is the target (slave) side of an I2C bus. It samples SCL and SDA through synchronizers on the system clock and recognises START, repeated START and STOP conditions. It compares the 7-bit address in the first byte of each transfer against two address slots, and each slot can be enabled on its own. When the address matches, the block acknowledges it and reports which slot hit. It then either stores written bytes through a byte-addressed receive memory port, or supplies read bytes from a byte-addressed transmit memory port. Two programmable maximum counts limit the receive and transmit transfers.

The surrounding logic sees single-cycle event pulses: addressed for read, addressed for write, transfer stopped, and error. It also sees three sticky error flags, which are cleared by writing ones, and the receive and transmit byte counts. When the master reads past the transmit limit, the block sends a programmable fill byte.

An optional mode holds SCL low after a read address is acknowledged. The hold lasts until the host has signalled that transmit data is prepared and has then issued a resume. A stop command forces the block back to idle at any time.

Top module: `i2c_dual_target`

## Requirements
- R1: After reset both line drivers are released, all error flags are zero and both byte counts are zero.
- R2: A write addressed to an enabled slot is acknowledged and raises `ev_write`. Each data byte is then acknowledged and written to receive address 0, 1, 2 and so on. `rx_amount` equals the number of bytes stored. The first byte is the 7-bit address followed by the direction bit, where 1 means read.
- R3: `match_index` is 0 for slot 0 and 1 for slot 1, and slot 0 wins when both slots match. An address that hits no enabled slot is not acknowledged, raises no event, and the following STOP raises no `ev_stopped`.
- R4: A read addressed to an enabled slot raises `ev_read` and returns the transmit memory bytes at addresses 0, 1 and so on. After STOP, `tx_amount` counts the buffered bytes that were fully sent.
- R5: Bytes read beyond `tx_max` carry `fill_byte` and are not counted. Each one sets `err_flags[1]` (over-read) and pulses `ev_error`.
- R6: A written byte beyond `rx_max` is not acknowledged and not stored. It sets `err_flags[0]` (overflow), and the rest of the transfer is ignored.
- R7: A master NACK after a transmitted byte sets `err_flags[2]`.
- R8: Each error flag stays set until a 1 is written to the same bit of `err_clear`. A new error in the same cycle wins over the clear.
- R9: With `rd_suspend_en` set, SCL is held low after a read address is acknowledged. A `task_resume` releases it only if a `task_prep_tx` came earlier in that transfer; a resume without one leaves SCL held.
- R10: A repeated START with the read direction after a write raises `ev_read`, and `rx_amount` keeps the count of the write phase.
- R11: A bus STOP after an addressed transfer pulses `ev_stopped`. `task_stop` returns the block to idle, releases both lines and pulses `ev_stopped`.
- R12: `ev_read`, `ev_write` and `ev_stopped` are single-cycle pulses, and no two of them are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| scl_drive_low | output | 1 | Pull SCL low (clock stretching) |
| sda_drive_low | output | 1 | Pull SDA low (ACK or data zero) |
| slot0_addr | input | 7 | Address of slot 0 |
| slot0_en | input | 1 | Enable for slot 0 |
| slot1_addr | input | 7 | Address of slot 1 |
| slot1_en | input | 1 | Enable for slot 1 |
| fill_byte | input | 8 | Byte sent once the transmit limit is reached |
| rd_suspend_en | input | 1 | Hold SCL after a read address until prepared and resumed |
| rx_max | input | 8 | Maximum bytes stored per write |
| tx_max | input | 8 | Maximum buffered bytes sent per read |
| task_prep_tx | input | 1 | Pulse: transmit data is ready |
| task_resume | input | 1 | Pulse: release a held SCL |
| task_stop | input | 1 | Pulse: force idle |
| err_clear | input | 3 | Write-one-to-clear for the error flags |
| rx_wr_en | output | 1 | Receive memory write strobe |
| rx_wr_addr | output | 8 | Receive memory address |
| rx_wr_data | output | 8 | Receive memory data |
| tx_rd_addr | output | 8 | Transmit memory address |
| tx_rd_data | input | 8 | Transmit memory data, combinational from tx_rd_addr |
| ev_read | output | 1 | Addressed-for-read pulse |
| ev_write | output | 1 | Addressed-for-write pulse |
| ev_stopped | output | 1 | Transfer-ended pulse |
| ev_error | output | 1 | Error pulse |
| err_flags | output | 3 | Sticky flags: bit0 overflow, bit1 over-read, bit2 data NACK |
| rx_amount | output | 8 | Bytes stored in the last write |
| tx_amount | output | 8 | Buffered bytes sent in the last read |
| match_index | output | 1 | Slot that matched the latest address |

## Verification
The bench builds the block with its default parameters: 8-bit counts and a two-stage synchronizer. With those, a bus quarter period of eight system clocks leaves several cycles of margin between a target-driven SDA change and the next SCL edge. The maximum counts are driven from 1 to 5, so the limit of both counters is hit within a few bytes. The fill, overflow and NACK paths are therefore reached many times in short random transfers. Directed runs cover the two slots, priority between them, a disabled slot, suspend with and without preparation, a repeated START and the forced stop.

// File: rtl/i2c_dual_target_pkg.sv
// Shared types and constants for the dual-address I2C target.
// Assumes 8-bit bytes and 7-bit addresses on the bus.
package i2c_dual_target_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int NUM_ERR  = 3;
    localparam int ERR_OVF  = 0;
    localparam int ERR_OVR  = 1;
    localparam int ERR_DNAK = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX_BITS,
        ST_RX_ACK,
        ST_TX_BITS,
        ST_TX_ACK,
        ST_SUSPEND,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sampler.sv
// Synchronizes SCL and SDA and flags edges and bus conditions.
// Assumes both lines idle high. START and STOP are recognised only when
// SCL is high in two successive samples.
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d, scl_now;

    // Shift both lines through the synchronizer chains and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
            scl_d  <= scl_sh[SYNC_STAGES-1];
            sda_d  <= sda_sh[SYNC_STAGES-1];
        end
    end

    // Decode edges and conditions from the current and previous samples.
    always_comb begin
        scl_now   = scl_sh[SYNC_STAGES-1];
        sda_lvl   = sda_sh[SYNC_STAGES-1];
        scl_rise  = scl_now & ~scl_d;
        scl_fall  = ~scl_now & scl_d;
        start_det = scl_now & scl_d & sda_d & ~sda_lvl;
        stop_det  = scl_now & scl_d & ~sda_d & sda_lvl;
    end

endmodule

// File: rtl/i2c_addr_match.sv
// Compares a received 7-bit address against NUM_SLOTS enabled slots.
// The lowest-numbered hitting slot wins. Purely combinational.
module i2c_addr_match #(
    parameter int NUM_SLOTS = 2,
    parameter int AW        = 7,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_SLOTS-1:0][AW-1:0] slot_addr,
    input  logic [NUM_SLOTS-1:0]         slot_en,
    input  logic [AW-1:0]                rx_addr,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);

    logic [NUM_SLOTS-1:0] hit_vec;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign hit_vec[g] = slot_en[g] && (slot_addr[g] == rx_addr);
    end

    // Pick the lowest hitting slot index.
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
        hit = |hit_vec;
    end

endmodule

// File: rtl/i2c_err_status.sv
// Holds the sticky error flags (write-one-to-clear) and pulses the error event.
// A set in the same cycle as a clear wins.
module i2c_err_status #(
    parameter int NUM_ERR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] err_set,
    input  logic [NUM_ERR-1:0] err_clr,
    output logic [NUM_ERR-1:0] err_q,
    output logic               ev_error
);

    // Update the sticky flags and register the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q    <= '0;
            ev_error <= 1'b0;
        end else begin
            err_q    <= (err_q & ~err_clr) | err_set;
            ev_error <= |err_set;
        end
    end

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_chk
        AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (err_q[g] && !err_clr[g]) |=> err_q[g]);                       // R8
        AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (err_clr[g] && !err_set[g]) |=> !err_q[g]);                    // R8
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
// Bit and byte sequencer of the I2C target: address phase, receive, transmit,
// acknowledge handling, read suspend and the byte counters.
// Assumes edge and condition pulses from i2c_line_sampler and a transmit
// memory whose data is valid in the same cycle as its address.
module i2c_tgt_engine
    import i2c_dual_target_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int IDX_W = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               hit,
    input  logic [IDX_W-1:0]   hit_idx,
    output logic [ADDR_W-1:0]  addr_rx,
    input  logic               rd_suspend_en,
    input  logic [BYTE_W-1:0]  fill_byte,
    input  logic [CNT_W-1:0]   rx_max,
    input  logic [CNT_W-1:0]   tx_max,
    input  logic               task_prep_tx,
    input  logic               task_resume,
    input  logic               task_stop,
    output logic               sda_oe_q,
    output logic               scl_hold_q,
    output logic               rx_we_q,
    output logic [CNT_W-1:0]   rx_waddr_q,
    output logic [BYTE_W-1:0]  rx_wdata_q,
    output logic [CNT_W-1:0]   tx_raddr,
    input  logic [BYTE_W-1:0]  tx_rdata,
    output logic [CNT_W-1:0]   rx_amt_q,
    output logic [CNT_W-1:0]   tx_amt_q,
    output logic [IDX_W-1:0]   match_q,
    output logic               ev_read_q,
    output logic               ev_write_q,
    output logic               ev_stopped_q,
    output logic [NUM_ERR-1:0] err_set_q
);

    tgt_state_e        state_q;
    logic [BYTE_W-1:0] shift_q;
    logic [3:0]        bit_cnt_q;
    logic              dir_rd_q, active_q, tx_ready_q, cur_buf_q, ack_q;
    logic              tx_in_range;
    logic [BYTE_W-1:0] load_byte;

    // Pick the next transmit byte: buffered data or the fill byte.
    always_comb begin
        tx_raddr    = tx_amt_q;
        tx_in_range = (tx_amt_q < tx_max);
        load_byte   = tx_in_range ? tx_rdata : fill_byte;
        addr_rx     = shift_q[BYTE_W-1:1];
    end

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            shift_q      <= '0;
            bit_cnt_q    <= '0;
            dir_rd_q     <= 1'b0;
            active_q     <= 1'b0;
            tx_ready_q   <= 1'b0;
            cur_buf_q    <= 1'b0;
            ack_q        <= 1'b0;
            sda_oe_q     <= 1'b0;
            rx_we_q      <= 1'b0;
            rx_waddr_q   <= '0;
            rx_wdata_q   <= '0;
            rx_amt_q     <= '0;
            tx_amt_q     <= '0;
            match_q      <= '0;
            ev_read_q    <= 1'b0;
            ev_write_q   <= 1'b0;
            ev_stopped_q <= 1'b0;
            err_set_q    <= '0;
        end else begin
            rx_we_q      <= 1'b0;
            ev_read_q    <= 1'b0;
            ev_write_q   <= 1'b0;
            ev_stopped_q <= 1'b0;
            err_set_q    <= '0;
            if (task_prep_tx) tx_ready_q <= 1'b1;

            if (task_stop) begin
                state_q      <= ST_IDLE;
                sda_oe_q     <= 1'b0;
                active_q     <= 1'b0;
                ev_stopped_q <= 1'b1;
            end else if (start_det) begin
                state_q   <= ST_ADDR;
                bit_cnt_q <= '0;
                sda_oe_q  <= 1'b0;
            end else if (stop_det) begin
                state_q      <= ST_IDLE;
                sda_oe_q     <= 1'b0;
                ev_stopped_q <= active_q;
                active_q     <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shift_q   <= {shift_q[BYTE_W-2:0], sda_lvl};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (scl_fall && bit_cnt_q == 4'd8) begin
                            if (hit) begin
                                state_q  <= ST_ADDR_ACK;
                                sda_oe_q <= 1'b1;
                                match_q  <= hit_idx;
                                active_q <= 1'b1;
                                dir_rd_q <= shift_q[0];
                                if (shift_q[0]) begin
                                    ev_read_q  <= 1'b1;
                                    tx_amt_q   <= '0;
                                    tx_ready_q <= 1'b0;
                                end else begin
                                    ev_write_q <= 1'b1;
                                    rx_amt_q   <= '0;
                                end
                            end else begin
                                state_q <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt_q <= '0;
                            if (dir_rd_q && rd_suspend_en) begin
                                state_q  <= ST_SUSPEND;
                                sda_oe_q <= 1'b0;
                            end else if (dir_rd_q) begin
                                state_q   <= ST_TX_BITS;
                                shift_q   <= load_byte;
                                sda_oe_q  <= ~load_byte[BYTE_W-1];
                                cur_buf_q <= tx_in_range;
                                err_set_q[ERR_OVR] <= ~tx_in_range;
                            end else begin
                                state_q  <= ST_RX_BITS;
                                sda_oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_SUSPEND: begin
                        if (task_resume && tx_ready_q) begin
                            state_q    <= ST_TX_BITS;
                            tx_ready_q <= 1'b0;
                            shift_q    <= load_byte;
                            sda_oe_q   <= ~load_byte[BYTE_W-1];
                            cur_buf_q  <= tx_in_range;
                            err_set_q[ERR_OVR] <= ~tx_in_range;
                        end
                    end
                    ST_TX_BITS: begin
                        if (scl_rise) begin
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                            if (bit_cnt_q == 4'd7 && cur_buf_q) tx_amt_q <= tx_amt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt_q == 4'd8) begin
                                state_q  <= ST_TX_ACK;
                                sda_oe_q <= 1'b0;
                            end else begin
                                shift_q  <= {shift_q[BYTE_W-2:0], 1'b0};
                                sda_oe_q <= ~shift_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            ack_q <= ~sda_lvl;
                        end else if (scl_fall) begin
                            bit_cnt_q <= '0;
                            if (ack_q) begin
                                state_q   <= ST_TX_BITS;
                                shift_q   <= load_byte;
                                sda_oe_q  <= ~load_byte[BYTE_W-1];
                                cur_buf_q <= tx_in_range;
                                err_set_q[ERR_OVR] <= ~tx_in_range;
                            end else begin
                                state_q <= ST_IGNORE;
                                err_set_q[ERR_DNAK] <= 1'b1;
                            end
                        end
                    end
                    ST_RX_BITS: begin
                        if (scl_rise) begin
                            shift_q   <= {shift_q[BYTE_W-2:0], sda_lvl};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (scl_fall && bit_cnt_q == 4'd8) begin
                            bit_cnt_q <= '0;
                            if (rx_amt_q < rx_max) begin
                                state_q    <= ST_RX_ACK;
                                sda_oe_q   <= 1'b1;
                                rx_we_q    <= 1'b1;
                                rx_waddr_q <= rx_amt_q;
                                rx_wdata_q <= shift_q;
                                rx_amt_q   <= rx_amt_q + 1'b1;
                            end else begin
                                state_q <= ST_IGNORE;
                                err_set_q[ERR_OVF] <= 1'b1;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            state_q  <= ST_RX_BITS;
                            sda_oe_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Hold SCL low one cycle after entering suspend, release one cycle after leaving.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_hold_q <= 1'b0;
        else        scl_hold_q <= (state_q == ST_SUSPEND);
    end

    AST_RX_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we_q |-> (rx_waddr_q < rx_max));                                // R6
    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_oe_q);                             // R3
    AST_HOLD_NEEDS_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold_q) |-> $past(rd_suspend_en));                       // R9
    AST_EVENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_read_q, ev_write_q, ev_stopped_q}));                  // R12

endmodule

// File: rtl/i2c_dual_target.sv
// Top of the dual-address I2C target: line sampler, address matcher,
// sequencer and error status. Open-drain outputs request a low level;
// the pad and pull-ups are outside this block.
module i2c_dual_target
    import i2c_dual_target_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               scl_drive_low,
    output logic               sda_drive_low,
    input  logic [6:0]         slot0_addr,
    input  logic               slot0_en,
    input  logic [6:0]         slot1_addr,
    input  logic               slot1_en,
    input  logic [7:0]         fill_byte,
    input  logic               rd_suspend_en,
    input  logic [CNT_W-1:0]   rx_max,
    input  logic [CNT_W-1:0]   tx_max,
    input  logic               task_prep_tx,
    input  logic               task_resume,
    input  logic               task_stop,
    input  logic [2:0]         err_clear,
    output logic               rx_wr_en,
    output logic [CNT_W-1:0]   rx_wr_addr,
    output logic [7:0]         rx_wr_data,
    output logic [CNT_W-1:0]   tx_rd_addr,
    input  logic [7:0]         tx_rd_data,
    output logic               ev_read,
    output logic               ev_write,
    output logic               ev_stopped,
    output logic               ev_error,
    output logic [2:0]         err_flags,
    output logic [CNT_W-1:0]   rx_amount,
    output logic [CNT_W-1:0]   tx_amount,
    output logic               match_index
);

    localparam int NUM_SLOTS = 2;
    localparam int IDX_W     = 1;

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic hit;
    logic [IDX_W-1:0] hit_idx, match_q;
    logic [ADDR_W-1:0] addr_rx;
    logic [NUM_ERR-1:0] err_set;
    logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
    logic [NUM_SLOTS-1:0] slot_en;

    assign slot_addr   = {slot1_addr, slot0_addr};
    assign slot_en     = {slot1_en, slot0_en};
    assign match_index = match_q[0];

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_addr_match #(.NUM_SLOTS(NUM_SLOTS), .AW(ADDR_W)) u_match (
        .slot_addr (slot_addr),
        .slot_en   (slot_en),
        .rx_addr   (addr_rx),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    i2c_tgt_engine #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .sda_lvl       (sda_lvl),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .hit           (hit),
        .hit_idx       (hit_idx),
        .addr_rx       (addr_rx),
        .rd_suspend_en (rd_suspend_en),
        .fill_byte     (fill_byte),
        .rx_max        (rx_max),
        .tx_max        (tx_max),
        .task_prep_tx  (task_prep_tx),
        .task_resume   (task_resume),
        .task_stop     (task_stop),
        .sda_oe_q      (sda_drive_low),
        .scl_hold_q    (scl_drive_low),
        .rx_we_q       (rx_wr_en),
        .rx_waddr_q    (rx_wr_addr),
        .rx_wdata_q    (rx_wr_data),
        .tx_raddr      (tx_rd_addr),
        .tx_rdata      (tx_rd_data),
        .rx_amt_q      (rx_amount),
        .tx_amt_q      (tx_amount),
        .match_q       (match_q),
        .ev_read_q     (ev_read),
        .ev_write_q    (ev_write),
        .ev_stopped_q  (ev_stopped),
        .err_set_q     (err_set)
    );

    i2c_err_status #(.NUM_ERR(NUM_ERR)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_set  (err_set),
        .err_clr  (err_clear),
        .err_q    (err_flags),
        .ev_error (ev_error)
    );

endmodule

// File: tb/i2c_dual_target_bench.sv
// Self-checking bench: an I2C master bus model drives directed and
// seeded random transfers; expected values come from bench functions.
module i2c_dual_target_bench;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_bus, sda_bus;
    logic scl_drive_low, sda_drive_low;
    logic [6:0] slot0_addr = 7'h55, slot1_addr = 7'h2A;
    logic slot0_en = 1'b1, slot1_en = 1'b1;
    logic [7:0] fill_byte = 8'hEE;
    logic rd_suspend_en = 1'b0;
    logic [7:0] rx_max = 8'd4, tx_max = 8'd4;
    logic task_prep_tx = 1'b0, task_resume = 1'b0, task_stop = 1'b0;
    logic [2:0] err_clear = 3'b000;
    logic rx_wr_en;
    logic [7:0] rx_wr_addr, rx_wr_data, tx_rd_addr, tx_rd_data;
    logic ev_read, ev_write, ev_stopped, ev_error;
    logic [2:0] err_flags;
    logic [7:0] rx_amount, tx_amount;
    logic match_index;

    assign scl_bus = ~(m_scl_low | scl_drive_low);
    assign sda_bus = ~(m_sda_low | sda_drive_low);

    i2c_dual_target u_i2c_dual_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .slot0_addr(slot0_addr), .slot0_en(slot0_en),
        .slot1_addr(slot1_addr), .slot1_en(slot1_en),
        .fill_byte(fill_byte), .rd_suspend_en(rd_suspend_en),
        .rx_max(rx_max), .tx_max(tx_max),
        .task_prep_tx(task_prep_tx), .task_resume(task_resume), .task_stop(task_stop),
        .err_clear(err_clear),
        .rx_wr_en(rx_wr_en), .rx_wr_addr(rx_wr_addr), .rx_wr_data(rx_wr_data),
        .tx_rd_addr(tx_rd_addr), .tx_rd_data(tx_rd_data),
        .ev_read(ev_read), .ev_write(ev_write), .ev_stopped(ev_stopped), .ev_error(ev_error),
        .err_flags(err_flags), .rx_amount(rx_amount), .tx_amount(tx_amount),
        .match_index(match_index)
    );

    // Transmit memory pattern and receive memory model.
    function automatic logic [7:0] pat(input int i);
        return 8'(i * 37 + 5);
    endfunction
    assign tx_rd_data = pat(int'(tx_rd_addr));

    logic [7:0] rx_mem [256];
    always @(posedge clk) if (rx_wr_en) rx_mem[rx_wr_addr] <= rx_wr_data;

    // Event and strobe counters.
    int n_read = 0, n_write = 0, n_stop = 0, n_err = 0, n_we = 0, n_multi = 0;
    always @(negedge clk) begin
        if (ev_read)    n_read++;
        if (ev_write)   n_write++;
        if (ev_stopped) n_stop++;
        if (ev_error)   n_err++;
        if (rx_wr_en)   n_we++;
        if (int'(ev_read) + int'(ev_write) + int'(ev_stopped) > 1) n_multi++;
    end

    int total = 0, bad = 0;
    logic done = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int exp_rd(input int i, input int lim, input logic [7:0] f);
        return (i < lim) ? int'(pat(i)) : int'(f);
    endfunction

    // ---- bus model ----
    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic scl_release();
        m_scl_low = 1'b0;
        while (scl_bus !== 1'b1) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b1; qwait(); m_scl_low = 1'b1; qwait();
    endtask

    task automatic m_rstart();
        m_sda_low = 1'b0; qwait(); scl_release(); qwait();
        m_sda_low = 1'b1; qwait(); m_scl_low = 1'b1; qwait();
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; qwait(); scl_release(); qwait();
        m_sda_low = 1'b0; qwait();
    endtask

    task automatic bit_out(input logic b);
        m_sda_low = ~b; qwait(); scl_release(); qwait(); qwait();
        m_scl_low = 1'b1; qwait();
    endtask

    task automatic bit_in(output logic b);
        m_sda_low = 1'b0; qwait(); scl_release(); qwait();
        b = sda_bus; qwait(); m_scl_low = 1'b1; qwait();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(x);
        ack = ~x;
    endtask

    task automatic rd_byte(input logic last, output logic [7:0] d);
        logic x;
        for (int i = 7; i >= 0; i--) begin bit_in(x); d[i] = x; end
        bit_out(last);
    endtask

    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    task automatic do_write(input logic [6:0] a, input int n, input logic stop_it,
                            output logic aack, output int nack_cnt);
        logic k;
        nack_cnt = 0;
        m_start();
        wr_byte({a, 1'b0}, aack);
        if (aack) begin
            for (int i = 0; i < n; i++) begin
                wr_byte(wbuf[i], k);
                if (!k) break;
                nack_cnt++;
            end
        end
        if (stop_it) m_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input int n, input logic rs, output logic aack);
        if (rs) m_rstart(); else m_start();
        wr_byte({a, 1'b1}, aack);
        if (aack) for (int i = 0; i < n; i++) rd_byte(i == n - 1, rbuf[i]);
        m_stop();
    endtask

    task automatic pulse_clear(input logic [2:0] m);
        @(negedge clk); err_clear = m; @(negedge clk); err_clear = 3'b000;
    endtask

    // ---- watchdog ----
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---- stimulus ----
    initial begin
        logic aack;
        int nk, b_rd, b_wr, b_st, b_er, b_we;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        check("R1 scl", int'(scl_drive_low), 0);
        check("R1 sda", int'(sda_drive_low), 0);
        check("R1 err", int'(err_flags), 0);
        check("R1 rxamt", int'(rx_amount), 0);
        check("R1 txamt", int'(tx_amount), 0);

        // R2 plain write to slot 0
        for (int i = 0; i < 3; i++) wbuf[i] = 8'(8'hA0 + i * 7);
        b_wr = n_write; b_st = n_stop;
        do_write(7'h55, 3, 1'b1, aack, nk);
        repeat (4) @(negedge clk);
        check("R2 addr ack", int'(aack), 1);
        check("R2 data acks", nk, 3);
        check("R2 ev_write", n_write - b_wr, 1);
        check("R2 rx_amount", int'(rx_amount), 3);
        for (int i = 0; i < 3; i++) check("R2 rx data", int'(rx_mem[i]), int'(wbuf[i]));
        check("R3 match slot0", int'(match_index), 0);
        check("R11 bus stop", n_stop - b_st, 1);

        // R3 slot 1, disabled slot, priority
        do_write(7'h2A, 2, 1'b1, aack, nk);
        check("R3 slot1 ack", int'(aack), 1);
        check("R3 match slot1", int'(match_index), 1);
        slot1_en = 1'b0;
        b_wr = n_write; b_st = n_stop; b_rd = n_read;
        do_write(7'h2A, 2, 1'b1, aack, nk);
        repeat (4) @(negedge clk);
        check("R3 disabled nack", int'(aack), 0);
        check("R3 no event", (n_write - b_wr) + (n_read - b_rd), 0);
        check("R3 no stopped", n_stop - b_st, 0);
        slot1_en = 1'b1; slot1_addr = 7'h55;
        do_write(7'h55, 1, 1'b1, aack, nk);
        check("R3 priority", int'(match_index), 0);
        slot1_addr = 7'h2A;

        // R4 and R7: read within limit
        pulse_clear(3'b111);
        tx_max = 8'd4; b_rd = n_read;
        do_read(7'h55, 3, 1'b0, aack);
        repeat (4) @(negedge clk);
        check("R4 ev_read", n_read - b_rd, 1);
        for (int i = 0; i < 3; i++) check("R4 data", int'(rbuf[i]), exp_rd(i, 4, fill_byte));
        check("R4 tx_amount", int'(tx_amount), 3);
        check("R7 dnack flag", int'(err_flags[2]), 1);
        check("R5 no overread", int'(err_flags[1]), 0);

        // R5 over-read
        pulse_clear(3'b111);
        tx_max = 8'd2; b_er = n_err;
        do_read(7'h55, 4, 1'b0, aack);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 4; i++) check("R5 data", int'(rbuf[i]), exp_rd(i, 2, fill_byte));
        check("R5 tx_amount", int'(tx_amount), 2);
        check("R5 overread flag", int'(err_flags[1]), 1);
        check("R5 ev_error", int'(n_err - b_er >= 2), 1);

        // R6 overflow, then R8 clear
        pulse_clear(3'b111);
        rx_max = 8'd2; b_we = n_we;
        for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'h30 + i);
        do_write(7'h55, 4, 1'b1, aack, nk);
        repeat (4) @(negedge clk);
        check("R6 acks", nk, 2);
        check("R6 writes", n_we - b_we, 2);
        check("R6 rx_amount", int'(rx_amount), 2);
        check("R6 flags", int'(err_flags), 3'b001);
        repeat (5) @(negedge clk);
        check("R8 sticky", int'(err_flags[0]), 1);
        pulse_clear(3'b010);
        check("R8 other bit kept", int'(err_flags[0]), 1);
        pulse_clear(3'b001);
        check("R8 cleared", int'(err_flags), 0);
        rx_max = 8'd4;

        // R9 suspend
        rd_suspend_en = 1'b1; tx_max = 8'd4; b_rd = n_read;
        fork
            do_read(7'h2A, 2, 1'b0, aack);
            begin
                while (n_read == b_rd) @(negedge clk);
                repeat (60) @(negedge clk);
                check("R9 held", int'(scl_drive_low), 1);
                task_resume = 1'b1; @(negedge clk); task_resume = 1'b0;
                repeat (20) @(negedge clk);
                check("R9 resume w/o prep", int'(scl_drive_low), 1);
                task_prep_tx = 1'b1; @(negedge clk); task_prep_tx = 1'b0;
                repeat (3) @(negedge clk);
                task_resume = 1'b1; @(negedge clk); task_resume = 1'b0;
                repeat (3) @(negedge clk);
                check("R9 released", int'(scl_drive_low), 0);
            end
        join
        for (int i = 0; i < 2; i++) check("R9 data", int'(rbuf[i]), exp_rd(i, 4, fill_byte));
        rd_suspend_en = 1'b0;

        // R10 write then repeated start read
        for (int i = 0; i < 3; i++) wbuf[i] = 8'(8'hC1 + i);
        b_rd = n_read;
        do_write(7'h55, 3, 1'b0, aack, nk);
        do_read(7'h55, 2, 1'b1, aack);
        repeat (4) @(negedge clk);
        check("R10 ev_read", n_read - b_rd, 1);
        check("R10 rx_amount kept", int'(rx_amount), 3);
        check("R10 tx_amount", int'(tx_amount), 2);

        // R11 forced stop
        b_st = n_stop;
        wbuf[0] = 8'h00;
        do_write(7'h55, 1, 1'b0, aack, nk);
        task_stop = 1'b1; @(negedge clk); task_stop = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 stop task event", n_stop - b_st, 1);
        check("R11 sda released", int'(sda_drive_low), 0);
        m_stop();
        repeat (4) @(negedge clk);
        check("R11 no second stop", n_stop - b_st, 1);

        // seeded random transfers
        for (int it = 0; it < 16; it++) begin
            int n, lim;
            logic [6:0] a;
            logic sl, rd;
            sl = 1'($urandom_range(0, 1));
            rd = 1'($urandom_range(0, 1));
            n = $urandom_range(1, 6);
            lim = $urandom_range(1, 5);
            a = sl ? 7'h2A : 7'h55;
            pulse_clear(3'b111);
            if (rd) begin
                tx_max = 8'(lim);
                do_read(a, n, 1'b0, aack);
                repeat (4) @(negedge clk);
                for (int i = 0; i < n; i++) check("R4 rnd data", int'(rbuf[i]), exp_rd(i, lim, fill_byte));
                check("R4 rnd tx_amount", int'(tx_amount), min2(n, lim));
                check("R5 rnd overread", int'(err_flags[1]), int'(n > lim));
            end else begin
                rx_max = 8'(lim);
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom_range(0, 255));
                do_write(a, n, 1'b1, aack, nk);
                repeat (4) @(negedge clk);
                check("R2 rnd acks", nk, min2(n, lim));
                check("R2 rnd rx_amount", int'(rx_amount), min2(n, lim));
                for (int i = 0; i < min2(n, lim); i++) check("R2 rnd data", int'(rx_mem[i]), int'(wbuf[i]));
                check("R6 rnd overflow", int'(err_flags[0]), int'(n > lim));
            end
            check("R3 rnd match", int'(match_index), int'(sl));
        end

        check("R12 exclusive events", n_multi, 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule